// File: doc/BRIEF.md
# Gate-Delay Serial Command Controller

This block lets a host program and read back the per-channel gate and delay settings of an external timing generator through a small register window. The host first loads a 32-bit value into a staging register. It then writes a command word that names an operation and a channel. The controller turns that command into a 48-bit serial frame and clocks it out over an SPI link, where it is the master.

The controller is busy while a frame is on the wire. A status bit shows when a new command may be accepted. A command that arrives too early is dropped, and the drop is remembered in a sticky error bit. Read commands capture the 32 bits the generator returns on MISO into a read-data register.

Register offsets: staging data at 0x7F00, command at 0x7F04, read data at 0x7F08, status at 0x7F10.

Command word fields: bits 15:12 hold the operation code (0x2 gate, 0x3 delay). Bit 8 is the read option. Bits 7:0 hold the channel.

Status bits: bit 0 is ready, bit 1 is the error flag.

Top module: `gdg_spi_ctrl`

## Requirements
- R1: After reset, status reads 0x1, read data reads 0, spi_cs_n is high and spi_sclk is low.
- R2: A command with code 0x2 (gate) or 0x3 (delay) and bit 8 clear sends one frame. The frame is opcode byte = command bits 15:8 (0x20 or 0x30), then the channel byte = command bits 7:0, then the 32-bit staging value.
- R3: Status bit 0 reads 0 from the cycle after a command is accepted until the frame has ended, and then reads 1 again.
- R4: The frame has 48 bits, sent MSB first in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and spi_cs_n stays low for the whole frame.
- R5: A command write while status bit 0 is 0 sends no frame and sets status bit 1.
- R6: Status bit 1 stays set until status is written with bit 1 = 1. Writing status with bit 1 = 0 leaves it unchanged.
- R7: A command with bit 8 set sends opcode 0x21 or 0x31. When the frame completes, the last 32 bits sampled on MISO are latched into the read-data register at 0x7F08.
- R8: A command whose code is neither 0x2 nor 0x3 starts no frame and leaves status at ready.
- R9: Each SCLK half-period lasts CLK_HALF system clocks.
- R10: A bus read returns, one cycle later, the register addressed in the previous cycle. The staging register reads back its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Frame select, active low |
| spi_mosi | output | 1 | Serial data to the generator |
| spi_miso | input | 1 | Serial data from the generator |

## Verification
The bench builds the block with CLK_HALF = 2, so a full 48-bit frame takes 192 system clocks. This makes it possible to land a second command deliberately inside a running frame, and then to run several frames back to back well within the cycle budget. A simple generator model keeps 256 gate and 256 delay entries and answers read frames from them. Write-then-read round trips on low and high channel numbers, and reads of channels that were never written, are therefore all checked.

// File: rtl/gdg_pkg.sv
package gdg_pkg;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 8;
  localparam int CH_W    = 8;
  localparam int FRAME_W = OP_W + CH_W + DATA_W;

  localparam logic [15:0] OFS_DATA   = 16'h7F00;
  localparam logic [15:0] OFS_CMD    = 16'h7F04;
  localparam logic [15:0] OFS_RDDATA = 16'h7F08;
  localparam logic [15:0] OFS_STATUS = 16'h7F10;

  typedef enum logic [3:0] {
    CODE_GATE  = 4'h2,
    CODE_DELAY = 4'h3
  } gdg_code_e;

  localparam int CODE_LSB = 12;
  localparam int RD_BIT   = 8;
endpackage

// File: rtl/gdg_cmd_decode.sv
module gdg_cmd_decode
  import gdg_pkg::*;
(
  input  logic [15:0]     cmd,
  output logic            valid,
  output logic            is_read,
  output logic [OP_W-1:0] opcode,
  output logic [CH_W-1:0] chan
);
  logic [3:0] code;

  always_comb begin
    code    = cmd[CODE_LSB +: 4];
    valid   = (code == CODE_GATE) || (code == CODE_DELAY);
    is_read = cmd[RD_BIT];
    opcode  = cmd[15:8];
    chan    = cmd[CH_W-1:0];
  end
endmodule

// File: rtl/gdg_spi_engine.sv
module gdg_spi_engine #(
  parameter int FRAME_W  = 48,
  parameter int RX_W     = 32,
  parameter int CLK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               done,
  output logic [RX_W-1:0]    rx,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int CW = $clog2(CLK_HALF) + 1;
  localparam int BW = $clog2(FRAME_W) + 1;

  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      sh   <= '0;
      cnt  <= '0;
      bitn <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cs_n <= 1'b0;
          sh   <= frame;
          cnt  <= '0;
          bitn <= '0;
          sclk <= 1'b0;
        end
      end else if (cnt == CW'(CLK_HALF - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[RX_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == BW'(FRAME_W - 1)) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mosi = sh[FRAME_W-1];
endmodule

// File: rtl/gdg_spi_ctrl.sv
module gdg_spi_ctrl
  import gdg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [DATA_W-1:0] data_q;
  logic [15:0]       cmd_q;
  logic [DATA_W-1:0] rdd_q;
  logic              err_q;
  logic              rd_pend;

  logic              cmd_hit, err_clr, eng_start, eng_busy, eng_done;
  logic              dec_valid, dec_read;
  logic [OP_W-1:0]   dec_op;
  logic [CH_W-1:0]   dec_ch;
  logic [DATA_W-1:0] eng_rx;

  gdg_cmd_decode u_dec (
    .cmd     (bus_wdata[15:0]),
    .valid   (dec_valid),
    .is_read (dec_read),
    .opcode  (dec_op),
    .chan    (dec_ch)
  );

  assign cmd_hit   = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
  assign err_clr   = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS)) && bus_wdata[1];
  assign eng_start = cmd_hit && !eng_busy && dec_valid;

  gdg_spi_engine #(
    .FRAME_W  (FRAME_W),
    .RX_W     (DATA_W),
    .CLK_HALF (CLK_HALF)
  ) u_eng (
    .clk   (clk),
    .rst   (rst),
    .start (eng_start),
    .frame ({dec_op, dec_ch, data_q}),
    .busy  (eng_busy),
    .done  (eng_done),
    .rx    (eng_rx),
    .sclk  (spi_sclk),
    .cs_n  (spi_cs_n),
    .mosi  (spi_mosi),
    .miso  (spi_miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      cmd_q   <= '0;
      rdd_q   <= '0;
      err_q   <= 1'b0;
      rd_pend <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(OFS_DATA) && !eng_busy)
        data_q <= bus_wdata;
      if (cmd_hit && eng_busy)
        err_q <= 1'b1;
      else if (err_clr)
        err_q <= 1'b0;
      if (eng_start) begin
        cmd_q   <= bus_wdata[15:0];
        rd_pend <= dec_read;
      end
      if (eng_done && rd_pend) begin
        rdd_q   <= eng_rx;
        rd_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_DATA):   bus_rdata <= data_q;
        ADDR_W'(OFS_CMD):    bus_rdata <= {16'h0, cmd_q};
        ADDR_W'(OFS_RDDATA): bus_rdata <= rdd_q;
        ADDR_W'(OFS_STATUS): bus_rdata <= {30'h0, err_q, !eng_busy};
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gdg_spi_ctrl_chk.sv
module gdg_spi_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic busy,
  input logic start,
  input logic err,
  input logic clr
);
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_cs_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);
endmodule

bind gdg_spi_ctrl gdg_spi_ctrl_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .sclk  (spi_sclk),
  .cs_n  (spi_cs_n),
  .mosi  (spi_mosi),
  .busy  (eng_busy),
  .start (eng_start),
  .err   (err_q),
  .clr   (err_clr)
);

// File: tb/gdg_spi_ctrl_tb.sv
`timescale 1ns/1ps
module gdg_spi_ctrl_tb;
  localparam int HALF = 2;
  localparam logic [15:0] A_DATA = 16'h7F00, A_CMD = 16'h7F04,
                          A_RDD  = 16'h7F08, A_STAT = 16'h7F10;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sclk, cs_n, mosi;
  logic miso = 1'b0;

  int total = 0, bad = 0, frames = 0, cyc = 0;
  logic [47:0] exp_q[$];
  logic [31:0] gate_m[256];
  logic [31:0] delay_m[256];
  logic [47:0] sl_sh;
  int sl_n = 0, t0 = 0, t1 = 0;
  logic [31:0] out_val;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gdg_spi_ctrl #(.ADDR_W(16), .CLK_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // generator model
  always @(negedge cs_n) begin
    sl_n = 0;
  end
  always @(posedge sclk) begin
    if (!cs_n) begin
      sl_sh = {sl_sh[46:0], mosi};
      if (sl_n == 0) t0 = cyc;
      if (sl_n == 1) t1 = cyc;
      sl_n++;
    end
  end
  always @(negedge sclk) begin
    if (!cs_n && sl_n >= 16 && sl_n < 48) begin
      if (sl_n == 16)
        out_val = (sl_sh[15:12] == 4'h2) ? gate_m[sl_sh[7:0]] : delay_m[sl_sh[7:0]];
      miso <= out_val[31 - (sl_n - 16)];
    end
  end
  // scoreboard monitor
  always @(posedge cs_n) begin
    if (sl_n == 48) begin
      logic [47:0] e;
      frames++;
      chk(t1 - t0 == 2 * HALF, "R9 sclk period", 64'(t1 - t0), 64'(2 * HALF));
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected frame", {16'h0, sl_sh}, 64'h0);
      end else begin
        e = exp_q.pop_front();
        chk(sl_sh == e, "R2/R4/R7 frame bits", {16'h0, sl_sh}, {16'h0, e});
      end
      if (sl_sh[40] == 1'b0) begin
        if (sl_sh[47:44] == 4'h2) gate_m[sl_sh[39:32]] = sl_sh[31:0];
        if (sl_sh[47:44] == 4'h3) delay_m[sl_sh[39:32]] = sl_sh[31:0];
      end
      sl_n = 0;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, s);
      if (s[0]) return;
    end
    chk(0, "R3 ready timeout", 64'(s), 64'h1);
  endtask

  task automatic send(input logic [15:0] c, input logic [31:0] d);
    exp_q.push_back({c[15:8], c[7:0], d});
    wr(A_CMD, {16'h0, c});
  endtask

  initial begin
    #(200000 * 20);
    chk(0, "watchdog", 64'(cyc), 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin
      gate_m[i] = '0;
      delay_m[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;

    rd(A_STAT, v);  chk(v == 32'h1, "R1 status", 64'(v), 64'h1);
    rd(A_RDD, v);   chk(v == 32'h0, "R1 rddata", 64'(v), 64'h0);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 spi idle", {62'h0, cs_n, sclk}, 64'h2);

    wr(A_DATA, 32'hA5C3_1F07);
    rd(A_DATA, v);  chk(v == 32'hA5C3_1F07, "R10 data readback", 64'(v), 64'hA5C31F07);

    send(16'h2005, 32'hA5C3_1F07);
    rd(A_STAT, v);  chk(v == 32'h0, "R3 busy", 64'(v), 64'h0);
    wait_ready();
    rd(A_STAT, v);  chk(v == 32'h1, "R3 ready after frame", 64'(v), 64'h1);
    chk(gate_m[5] == 32'hA5C3_1F07, "R2 gate write", 64'(gate_m[5]), 64'hA5C31F07);

    wr(A_DATA, 32'h0000_0BEE);
    send(16'h30C8, 32'h0000_0BEE);
    wr(A_CMD, 32'h3009);
    rd(A_STAT, v);  chk(v == 32'h2, "R5 error while busy", 64'(v), 64'h2);
    wait_ready();
    rd(A_STAT, v);  chk(v == 32'h3, "R5 R6 sticky error", 64'(v), 64'h3);
    chk(delay_m[9] == 32'h0, "R5 ignored command", 64'(delay_m[9]), 64'h0);
    chk(delay_m[200] == 32'hBEE, "R2 delay write", 64'(delay_m[200]), 64'hBEE);

    wr(A_STAT, 32'h0);
    rd(A_STAT, v);  chk(v == 32'h3, "R6 no clear on bit1=0", 64'(v), 64'h3);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v);  chk(v == 32'h1, "R6 clear", 64'(v), 64'h1);

    send(16'h2105, 32'h0000_0BEE);
    wait_ready();
    rd(A_RDD, v);   chk(v == 32'hA5C3_1F07, "R7 gate readback", 64'(v), 64'hA5C31F07);

    send(16'h31C8, 32'h0000_0BEE);
    wait_ready();
    rd(A_RDD, v);   chk(v == 32'hBEE, "R7 delay readback", 64'(v), 64'hBEE);

    send(16'h214D, 32'h0000_0BEE);
    wait_ready();
    rd(A_RDD, v);   chk(v == 32'h0, "R7 unwritten channel", 64'(v), 64'h0);

    wr(A_CMD, 32'h5005);
    rd(A_STAT, v);  chk(v == 32'h1, "R8 bad code ready", 64'(v), 64'h1);
    wr(A_CMD, 32'h0105);
    repeat (50) @(negedge clk);
    chk(frames == 5, "R8 no frame for bad code", 64'(frames), 64'd5);
    chk(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule